// File: doc/BRIEF.md
# One-Cycle Instruction Prefix Unit

This block stores a prefix word and a three-bit selector that one instruction writes for the benefit of the instruction that follows it. From the stored word it presents a high-order data byte. From the selector it presents extended register-address bits: one for the source operand and two for the destination operand. The word and the selector last for exactly one instruction. When the following instruction retires, both return to zero. In that idle state, destinations are limited to registers 00h–07h and sources to 00h–0Fh.

A write sets the stored state at the next clock edge. The pipeline raises an advance strobe when an instruction completes. An edge that sees advance without a write ends the prefix lifetime. An edge that sees neither leaves the state as it is, which covers a stalled instruction. A write always sets up a new lifetime, even when the previous prefix is still live. All eight selector codes write into the same 16-bit storage. The selector changes only the address bits that are presented. The read port shows the stored word.

Top module: `prefix_hold_unit`

## Requirements
- R1: While rst_n is low, rd_data, pfx_byte, src_hi and dst_hi are all zero.
- R2: A clock edge with wr_en=1 stores all 16 bits of wr_data for every wr_idx code (0 to 7). rd_data shows the stored word after that edge.
- R3: pfx_byte always equals bits 7:0 of the word shown on rd_data.
- R4: After a write edge, src_hi equals wr_idx bit 0. The value 0 means a source range of 00h–0Fh and 1 means 10h–1Fh.
- R5: After a write edge, dst_hi equals wr_idx bits 2:1. The destination range starts at dst_hi*8 and spans eight registers: 00h, 08h, 10h or 18h.
- R6: A clock edge with advance=1 and wr_en=0 returns rd_data, pfx_byte, src_hi and dst_hi to zero. They stay zero until the next write.
- R7: A clock edge with advance=0 and wr_en=0 leaves all outputs unchanged. This holds whatever value wr_data and wr_idx carry.
- R8: A clock edge with wr_en=1 and advance=1 loads the new word and selector and starts a new lifetime. The expiry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous by default |
| wr_en | input | 1 | Prefix write strobe |
| wr_idx | input | 3 | Selector written together with the word |
| wr_data | input | 16 | Prefix word to store |
| advance | input | 1 | An instruction completes at this edge |
| rd_data | output | 16 | Stored prefix word |
| pfx_byte | output | 8 | High-order data byte for the next instruction |
| src_hi | output | 1 | Source register address bit 4 |
| dst_hi | output | 2 | Destination register address bits 4:3 |

## Verification
The assertions assume that wr_en, advance, wr_idx and wr_data are free of X and change only between clock edges. The checker is disabled while reset is low, so it relies on a known reset at the start. The bench drives every input on the falling edge and releases reset before it issues any command. Its random commands cover all four combinations of write and advance, including back-to-back writes and stalls with random data on the write bus.

// File: rtl/prefix_pkg.sv
package prefix_pkg;
   // What the next clock edge does to the stored prefix state
   typedef enum logic [1:0] {
      PFX_HOLD   = 2'd0,
      PFX_LOAD   = 2'd1,
      PFX_EXPIRE = 2'd2
   } pfx_act_e;
endpackage

// File: rtl/pfx_lifetime.sv
module pfx_lifetime
   import prefix_pkg::*;
(
   input  logic     wr_en,
   input  logic     advance,
   output pfx_act_e act
);
   // A write always wins; otherwise a completed instruction ends the lifetime
   always_comb begin
      if (wr_en)        act = PFX_LOAD;
      else if (advance) act = PFX_EXPIRE;
      else              act = PFX_HOLD;
   end
endmodule

// File: rtl/pfx_store.sv
module pfx_store
   import prefix_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int IDX_W     = 3,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pfx_act_e          act,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [IDX_W-1:0]  ld_idx,
   output logic [DATA_W-1:0] val_q,
   output logic [IDX_W-1:0]  idx_q
);
   logic [DATA_W-1:0] val_d;
   logic [IDX_W-1:0]  idx_d;

   always_comb begin
      unique case (act)
         PFX_LOAD: begin
            val_d = ld_data;
            idx_d = ld_idx;
         end
         PFX_EXPIRE: begin
            val_d = '0;
            idx_d = '0;
         end
         default: begin
            val_d = val_q;
            idx_d = idx_q;
         end
      endcase
   end

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
               idx_q <= '0;
            end else begin
               val_q <= val_d;
               idx_q <= idx_d;
            end
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               val_q <= '0;
               idx_q <= '0;
            end else begin
               val_q <= val_d;
               idx_q <= idx_d;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pfx_decode.sv
module pfx_decode #(
   parameter int IDX_W  = 3,
   parameter int BYTE_W = 8,
   localparam int DST_W = IDX_W - 1
) (
   input  logic [BYTE_W-1:0] low_bits,
   input  logic [IDX_W-1:0]  idx_q,
   output logic [BYTE_W-1:0] pfx_byte,
   output logic              src_hi,
   output logic [DST_W-1:0]  dst_hi
);
   // Selector bit 0 picks the source bank; the upper bits pick the destination group
   assign pfx_byte = low_bits;
   assign src_hi   = idx_q[0];
   assign dst_hi   = idx_q[IDX_W-1:1];
endmodule

// File: rtl/prefix_hold_unit.sv
module prefix_hold_unit
   import prefix_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int IDX_W     = 3,
   parameter int BYTE_W    = 8,
   parameter bit ASYNC_RST = 1'b1,
   localparam int DST_W    = IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              advance,
   output logic [DATA_W-1:0] rd_data,
   output logic [BYTE_W-1:0] pfx_byte,
   output logic              src_hi,
   output logic [DST_W-1:0]  dst_hi
);
   generate
      if (BYTE_W < 1 || BYTE_W > DATA_W) begin : g_bad_byte
         $error("prefix_hold_unit: BYTE_W must lie in 1..DATA_W");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("prefix_hold_unit: IDX_W must be at least 2");
      end
   endgenerate

   pfx_act_e          act;
   logic [DATA_W-1:0] val_q;
   logic [IDX_W-1:0]  idx_q;

   pfx_lifetime i_life (
      .wr_en   (wr_en),
      .advance (advance),
      .act     (act)
   );

   pfx_store #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .ASYNC_RST (ASYNC_RST)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .ld_data (wr_data),
      .ld_idx  (wr_idx),
      .val_q   (val_q),
      .idx_q   (idx_q)
   );

   pfx_decode #(
      .IDX_W  (IDX_W),
      .BYTE_W (BYTE_W)
   ) i_dec (
      .low_bits (val_q[BYTE_W-1:0]),
      .idx_q    (idx_q),
      .pfx_byte (pfx_byte),
      .src_hi   (src_hi),
      .dst_hi   (dst_hi)
   );

   assign rd_data = val_q;
endmodule

// File: rtl/prefix_hold_checker.sv
module prefix_hold_checker #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 3,
   parameter int BYTE_W = 8,
   localparam int DST_W = IDX_W - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              advance,
   input logic [DATA_W-1:0] rd_data,
   input logic [BYTE_W-1:0] pfx_byte,
   input logic              src_hi,
   input logic [DST_W-1:0]  dst_hi
);
   a_r2_load_word: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(wr_data));

   a_r3_byte_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_byte == rd_data[BYTE_W-1:0]);

   a_r4_src_bank: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> src_hi == $past(wr_idx[0]));

   a_r5_dst_group: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> dst_hi == $past(wr_idx[IDX_W-1:1]));

   a_r6_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !wr_en) |=> (rd_data == '0 && !src_hi && dst_hi == '0));

   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !wr_en) |=> ($stable(rd_data) && $stable(src_hi) && $stable(dst_hi)));

   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && wr_en) |=> rd_data == $past(wr_data));
endmodule

bind prefix_hold_unit prefix_hold_checker #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .BYTE_W (BYTE_W)
) i_chk (.*);

// File: tb/test_prefix_hold_unit.sv
`timescale 1ns/1ps
module test_prefix_hold_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic        advance = 1'b0;
   logic [15:0] rd_data;
   logic [7:0]  pfx_byte;
   logic        src_hi;
   logic [1:0]  dst_hi;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [15:0] m_val = '0;
   logic [2:0]  m_idx = '0;

   always #2 clk = ~clk;

   prefix_hold_unit i_prefix_hold_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .advance(advance), .rd_data(rd_data),
      .pfx_byte(pfx_byte), .src_hi(src_hi), .dst_hi(dst_hi)
   );

   // Expected source bank base from the selector
   function automatic int src_base(input logic [2:0] idx);
      return idx[0] ? 16 : 0;
   endfunction

   // Expected destination group base from the selector
   function automatic int dst_base(input logic [2:0] idx);
      return int'(idx[2:1]) * 8;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " rd_data"}, int'(rd_data), int'(m_val));
      chk("R3 pfx_byte", int'(pfx_byte), int'(m_val[7:0]));
      chk("R4 src_hi", src_hi ? 16 : 0, src_base(m_idx));
      chk("R5 dst_hi", int'(dst_hi) * 8, dst_base(m_idx));
   endtask

   // One clock: drive at the falling edge, model the rising edge, check at the next fall
   task automatic step(input bit w, input bit a, input logic [2:0] idx, input logic [15:0] d);
      string tag;
      wr_en = w; advance = a; wr_idx = idx; wr_data = d;
      @(posedge clk);
      if (w) begin
         m_val = d; m_idx = idx;
      end else if (a) begin
         m_val = '0; m_idx = '0;
      end
      @(negedge clk);
      if (w && a)      tag = "R8";
      else if (w)      tag = "R2";
      else if (a)      tag = "R6";
      else             tag = "R7";
      check_all(tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_0017));
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2 R4 R5: every selector code lands in the same storage
      for (int k = 0; k < 8; k++) begin
         step(1'b1, 1'b0, 3'(k), 16'hA500 + 16'(k * 17));
         step(1'b0, 1'b1, 3'd0, 16'h0);
      end
      // R7: stall with noise on the write bus, then expire (R6)
      step(1'b1, 1'b0, 3'd7, 16'hBEEF);
      step(1'b0, 1'b0, 3'd2, 16'h1234);
      step(1'b0, 1'b0, 3'd5, 16'hFFFF);
      step(1'b0, 1'b1, 3'd3, 16'h5555);
      step(1'b0, 1'b1, 3'd6, 16'h7777);
      // R8: back-to-back writes, then a write on the advance edge
      step(1'b1, 1'b0, 3'd1, 16'h00FF);
      step(1'b1, 1'b1, 3'd6, 16'hFF00);
      step(1'b0, 1'b1, 3'd0, 16'h0);

      for (int n = 0; n < 400; n++) begin
         step(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom));
      end

      // R1: reset in the middle of a live prefix
      step(1'b1, 1'b0, 3'd5, 16'hC3C3);
      rst_n = 1'b0;
      m_val = '0; m_idx = '0;
      @(negedge clk);
      check_all("R1");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule